// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter

This block is a synchronous binary counter that counts in either direction and can be preset. Every control input is active low. An asynchronous master reset clears the state at once. A synchronous reset, a parallel load and a counting step take effect on the rising clock edge, in that order of precedence. If none of them applies, the counter holds its value. Counting requires two enables, a parallel one and a trickle one, and both must be asserted. A direction input selects whether the counter increments or decrements. The count width is a parameter, with a default of 4 bits.

The block drives three kinds of output. The first is a terminal-count flag for building wider counters; it is decoded combinationally from the state, the direction and the trickle enable. The second is a clocked carry, which is low only during the low phase of the clock, so it is clean enough to clock another stage. The third is the count value itself, driven through a tri-state stage with an output enable. Disabling that stage floats the outputs but does not stop the counter.

Top module: `updown_counter`

## Requirements
- R1: The state counts modulo 2^WIDTH. Counting up from all ones gives 0, and counting down from 0 gives all ones (15 and 0 at WIDTH=4).
- R2: A low `mrst_n` clears the state immediately, without waiting for a clock edge, and overrides every other input.
- R3: A low `clr_n` while `mrst_n` is high clears the state on the next rising edge. It takes precedence over loading and counting.
- R4: A low `ld_n` while both resets are high copies `din` into the state on the next rising edge. It takes precedence over counting.
- R5: When both resets and `ld_n` are high, the state advances on a rising edge only if `en_par_n` and `en_tri_n` are both low. If either enable is high, the state holds.
- R6: During a counting step, `up_dn`=1 increments the state by one and `up_dn`=0 decrements it by one.
- R7: `tc_n` is low exactly when `en_tri_n` is low and the state is either all ones with `up_dn`=1 or zero with `up_dn`=0. It follows changes of `up_dn` and `en_tri_n` without waiting for a clock edge.
- R8: `cc_n` is low only while `clk` is low and, at the same time, `en_par_n`, `en_tri_n` and `tc_n` are low and `clr_n` and `ld_n` are high. Otherwise `cc_n` is high, and it is always high while `clk` is high.
- R9: When `oe_n` is low, `dout` shows the state. When `oe_n` is high, every bit of `dout` is high impedance, and loading, clearing and counting continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous changes occur on its rising edge |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| clr_n | input | 1 | Synchronous reset, active low |
| ld_n | input | 1 | Parallel load enable, active low |
| en_par_n | input | 1 | Parallel count enable, active low |
| en_tri_n | input | 1 | Trickle count enable, active low; also gates `tc_n` |
| up_dn | input | 1 | Count direction: 1 counts up, 0 counts down |
| oe_n | input | 1 | Output enable for `dout`, active low |
| din | input | WIDTH | Value loaded into the state |
| dout | output | WIDTH | Count value, or high impedance when disabled |
| tc_n | output | 1 | Terminal count, active low |
| cc_n | output | 1 | Clocked carry, active low |

## Verification
Results that pass through a register (clear, load, count, hold and wrap) are due one rising edge after the stimulus. The bench changes inputs just after a rising edge and reads `dout` one nanosecond after the next rising edge, so it sees the new state. The master reset, the terminal count and the tri-state enable take effect in the same cycle, and they are checked a nanosecond after the input changes, with no clock edge in between. The clocked carry is read a nanosecond after a falling edge, to see its low phase, and again a nanosecond after the following rising edge, where it must be high.

// File: rtl/updown_counter_pkg.sv
package updown_counter_pkg;

    // Operation selected for the next rising edge (asynchronous reset is handled in the register)
    typedef enum logic [2:0] {
        MODE_HOLD  = 3'd0,
        MODE_CLEAR = 3'd1,
        MODE_LOAD  = 3'd2,
        MODE_UP    = 3'd3,
        MODE_DOWN  = 3'd4
    } mode_e;

endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
    import updown_counter_pkg::*;
(
    input  logic  clr_n,
    input  logic  ld_n,
    input  logic  en_par_n,
    input  logic  en_tri_n,
    input  logic  up_dn,
    output mode_e mode
);
    // Fixed precedence: clear, load, count, hold
    always_comb begin
        if (!clr_n)
            mode = MODE_CLEAR;
        else if (!ld_n)
            mode = MODE_LOAD;
        else if (!en_par_n && !en_tri_n)
            mode = up_dn ? MODE_UP : MODE_DOWN;
        else
            mode = MODE_HOLD;
    end
endmodule

// File: rtl/cnt_step.sv
module cnt_step
    import updown_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  mode_e            mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Natural wrap of WIDTH-bit arithmetic gives the modulo behaviour
    always_comb begin
        unique case (mode)
            MODE_CLEAR: nxt = '0;
            MODE_LOAD:  nxt = din;
            MODE_UP:    nxt = cur + ONE;
            MODE_DOWN:  nxt = cur - ONE;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/cnt_flags.sv
module cnt_flags #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] cnt,
    input  logic             up_dn,
    input  logic             en_par_n,
    input  logic             en_tri_n,
    input  logic             clr_n,
    input  logic             ld_n,
    output logic             tc_n,
    output logic             cc_n
);
    logic at_top;
    logic at_bottom;
    logic tc_act;
    logic step_ok;

    assign at_top    = &cnt;
    assign at_bottom = ~|cnt;
    assign tc_act    = !en_tri_n && (up_dn ? at_top : at_bottom);
    assign tc_n      = !tc_act;

    // Carry only when a counting step is really selected
    assign step_ok = clr_n && ld_n && !en_par_n && tc_act;
    assign cc_n    = !(step_ok && !clk);
endmodule

// File: rtl/cnt_drive.sv
module cnt_drive #(
    parameter int WIDTH = 4
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] cnt,
    output wire  [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign dout[b] = oe_n ? 1'bz : cnt[b];
    end
endmodule

// File: rtl/updown_counter.sv
module updown_counter
    import updown_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic             en_par_n,
    input  logic             en_tri_n,
    input  logic             up_dn,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] din,
    output wire  [WIDTH-1:0] dout,
    output logic             tc_n,
    output logic             cc_n
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    mode_e            mode;
    logic [WIDTH-1:0] step_nxt;

    cnt_mode_sel u_mode (
        .clr_n    (clr_n),
        .ld_n     (ld_n),
        .en_par_n (en_par_n),
        .en_tri_n (en_tri_n),
        .up_dn    (up_dn),
        .mode     (mode)
    );

    cnt_step #(.WIDTH(WIDTH)) u_step (
        .mode (mode),
        .cur  (st_q.cnt),
        .din  (din),
        .nxt  (step_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = step_nxt;
    end

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    cnt_flags #(.WIDTH(WIDTH)) u_flags (
        .clk      (clk),
        .cnt      (st_q.cnt),
        .up_dn    (up_dn),
        .en_par_n (en_par_n),
        .en_tri_n (en_tri_n),
        .clr_n    (clr_n),
        .ld_n     (ld_n),
        .tc_n     (tc_n),
        .cc_n     (cc_n)
    );

    cnt_drive #(.WIDTH(WIDTH)) u_drive (
        .oe_n (oe_n),
        .cnt  (st_q.cnt),
        .dout (dout)
    );
endmodule

// File: rtl/updown_counter_chk.sv
module updown_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             mrst_n,
    input logic             clr_n,
    input logic             ld_n,
    input logic             en_par_n,
    input logic             en_tri_n,
    input logic             up_dn,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] cnt,
    input logic             tc_n,
    input logic             cc_n
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // R2: state reads zero at any edge while master reset is held
    always @(posedge clk) begin
        if (!mrst_n)
            assert_mrst_zero_R2: assert (cnt == '0);
    end

    // R3
    assert_clear_R3: assert property (@(posedge clk) disable iff (!mrst_n)
        !clr_n |=> cnt == '0);

    // R4
    assert_load_R4: assert property (@(posedge clk) disable iff (!mrst_n)
        clr_n && !ld_n |=> cnt == $past(din));

    // R5
    assert_hold_R5: assert property (@(posedge clk) disable iff (!mrst_n)
        clr_n && ld_n && (en_par_n || en_tri_n) |=> $stable(cnt));

    // R6 and R1: up step, wrap included
    assert_up_step_R6: assert property (@(posedge clk) disable iff (!mrst_n)
        clr_n && ld_n && !en_par_n && !en_tri_n && up_dn |=> cnt == $past(cnt) + ONE);

    // R6 and R1: down step, wrap included
    assert_down_step_R1: assert property (@(posedge clk) disable iff (!mrst_n)
        clr_n && ld_n && !en_par_n && !en_tri_n && !up_dn |=> cnt == $past(cnt) - ONE);

    // R7: terminal count never active without trickle enable
    assert_tc_gate_R7: assert property (@(posedge clk) disable iff (!mrst_n)
        !tc_n |-> !en_tri_n);

    // R8: carry is high throughout the clock high phase
    assert_cc_high_R8: assert property (@(negedge clk) disable iff (!mrst_n)
        cc_n);
endmodule

bind updown_counter updown_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .en_par_n (en_par_n),
    .en_tri_n (en_tri_n),
    .up_dn    (up_dn),
    .din      (din),
    .cnt      (st_q.cnt),
    .tc_n     (tc_n),
    .cc_n     (cc_n)
);

// File: tb/updown_counter_test.sv
`timescale 1ns/1ps
module updown_counter_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         mrst_n, clr_n, ld_n, en_par_n, en_tri_n, up_dn, oe_n;
    logic [W-1:0] din;
    wire  [W-1:0] dout;
    logic         tc_n, cc_n;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    updown_counter #(.WIDTH(W)) uut (
        .clk(clk), .mrst_n(mrst_n), .clr_n(clr_n), .ld_n(ld_n),
        .en_par_n(en_par_n), .en_tri_n(en_tri_n), .up_dn(up_dn), .oe_n(oe_n),
        .din(din), .dout(dout), .tc_n(tc_n), .cc_n(cc_n)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic edge_then_settle();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        clr_n = 1; ld_n = 1; en_par_n = 1; en_tri_n = 1; up_dn = 1; oe_n = 0;
    endtask

    task automatic load_val(input logic [W-1:0] v);
        ld_n = 0; din = v;
        edge_then_settle();
        ld_n = 1;
    endtask

    task automatic t_reset();
        chk("R2 reset state", dout, 4'd0);
        load_val(4'd9);
        en_par_n = 0; en_tri_n = 0; ld_n = 0; din = 4'd3;
        #0.5 mrst_n = 0;
        #0.5 chk("R2 async clear mid cycle", dout, 4'd0);
        edge_then_settle();
        chk("R2 overrides load and count", dout, 4'd0);
        mrst_n = 1; idle();
        edge_then_settle();
    endtask

    task automatic t_wrap_up();
        load_val(4'd14);
        up_dn = 1; en_par_n = 0; en_tri_n = 0;
        edge_then_settle();
        chk("R6 up step", dout, 4'd15);
        edge_then_settle();
        chk("R1 wrap 15 to 0", dout, 4'd0);
        idle();
    endtask

    task automatic t_wrap_down();
        load_val(4'd1);
        up_dn = 0; en_par_n = 0; en_tri_n = 0;
        edge_then_settle();
        chk("R6 down step", dout, 4'd0);
        edge_then_settle();
        chk("R1 wrap 0 to 15", dout, 4'd15);
        idle();
    endtask

    task automatic t_hold();
        load_val(4'd6);
        en_par_n = 1; en_tri_n = 0;
        edge_then_settle();
        chk("R5 hold par high", dout, 4'd6);
        en_par_n = 0; en_tri_n = 1;
        edge_then_settle();
        chk("R5 hold tri high", dout, 4'd6);
        idle();
    endtask

    task automatic t_priority();
        load_val(4'd7);
        en_par_n = 0; en_tri_n = 0; ld_n = 0; din = 4'd12;
        edge_then_settle();
        chk("R4 load beats count", dout, 4'd12);
        clr_n = 0;
        edge_then_settle();
        chk("R3 clear beats load and count", dout, 4'd0);
        idle();
    endtask

    task automatic t_tc();
        load_val(4'd15);
        up_dn = 1; en_tri_n = 0;
        #1 chk("R7 tc low at 15 up", {3'b0, tc_n}, 4'd0);
        up_dn = 0;
        #1 chk("R7 tc released by direction", {3'b0, tc_n}, 4'd1);
        up_dn = 1; en_tri_n = 1;
        #1 chk("R7 tc released by trickle", {3'b0, tc_n}, 4'd1);
        idle();
        load_val(4'd0);
        up_dn = 0; en_tri_n = 0;
        #1 chk("R7 tc low at 0 down", {3'b0, tc_n}, 4'd0);
        idle();
    endtask

    task automatic t_cc();
        load_val(4'd15);
        up_dn = 1; en_par_n = 0; en_tri_n = 0;
        @(negedge clk); #1;
        chk("R8 cc low in clock low phase", {3'b0, cc_n}, 4'd0);
        edge_then_settle();
        chk("R8 cc high in clock high phase", {3'b0, cc_n}, 4'd1);
        chk("R1 carry step wrapped", dout, 4'd0);
        idle();
        load_val(4'd15);
        en_par_n = 0; en_tri_n = 0; ld_n = 0; din = 4'd15;
        @(negedge clk); #1;
        chk("R8 cc high during load", {3'b0, cc_n}, 4'd1);
        idle();
        en_par_n = 1; en_tri_n = 0;
        @(negedge clk); #1;
        chk("R8 cc high without parallel enable", {3'b0, cc_n}, 4'd1);
        idle();
        edge_then_settle();
    endtask

    task automatic t_oe();
        load_val(4'd4);
        oe_n = 1;
        #1 chk("R9 outputs float", dout, 4'bzzzz);
        up_dn = 1; en_par_n = 0; en_tri_n = 0;
        edge_then_settle();
        edge_then_settle();
        en_par_n = 1;
        oe_n = 0;
        #1 chk("R9 counted while floating", dout, 4'd6);
        oe_n = 1; ld_n = 0; din = 4'd10;
        edge_then_settle();
        ld_n = 1; oe_n = 0;
        #1 chk("R9 loaded while floating", dout, 4'd10);
        idle();
    endtask

    initial begin
        mrst_n = 0; idle(); din = '0;
        #1;
        edge_then_settle();
        mrst_n = 1;
        t_reset();
        t_wrap_up();
        t_wrap_down();
        t_hold();
        t_priority();
        t_tc();
        t_cc();
        t_oe();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule